// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the operating mode of an SDRAM device and produces the column addresses for each access burst. A mode-set strobe carries a 12-bit address word. The word is decoded into a burst length, a beat ordering (sequential or interleaved), a CAS latency and a write-burst override. A well-formed command that arrives while no bank is busy is staged. It then takes effect two clock cycles after the edge that accepted it. A malformed command, or one that arrives at the wrong time, raises an error pulse and leaves the settings as they were.

A burst-start strobe with a starting column and a read/write flag launches a burst. From the next cycle on, the block presents one column per cycle with a valid flag, and it marks the final beat of a fixed-length burst. A full-page burst walks the whole page and wraps. It stops only when the terminate strobe arrives.

Top module: `sdram_mode_burst_seq`

## Requirements
- R1: Address bits [2:0] encode the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page (2^COL_W beats); `cfg_burst_len` shows the active length.
- R2: Address bit 3 set selects interleaved order and clear selects sequential; with full page the order is forced sequential and `cfg_interleave` reads 0.
- R3: Address bits [6:4] encode CAS latency 001=1, 010=2, 011=3, shown on `cfg_cas_lat` as that number.
- R4: A command with an invalid length code (100,101,110), an invalid latency code (000,1xx), or any reserved bit set (bits 7, 8, 10, 11) pulses `mode_err` for one cycle after its edge and changes no setting; a valid accepted command leaves `mode_err` low.
- R5: A mode-set is rejected with `mode_err` while `bank_busy` is high, or while an earlier accepted command is still waiting to take effect.
- R6: An accepted command changes the configuration outputs exactly two edges after the accepting edge, not earlier; `mode_ready` rises at the same edge.
- R7: After reset the burst length is 1, the order is sequential, the CAS latency is 2, `mode_ready` is 0, and `burst_valid` and `mode_err` are 0.
- R8: A sequential burst increments the column and wraps inside the block of burst-length columns aligned to that length.
- R9: An interleaved burst emits start column XOR beat index within the aligned block.
- R10: A full-page burst increments modulo the page, never asserts `burst_last`, and runs until `burst_stop`.
- R11: A fixed-length burst asserts `burst_last` on its final beat, and `burst_valid` falls on the next cycle.
- R12: With address bit 9 set, write bursts last one beat while read bursts keep the programmed length.
- R13: `burst_stop` ends an active burst at the next edge; `burst_start` during a burst restarts it at the new column (start wins over stop).
- R14: The first column equals `start_col` and appears in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set | input | 1 | Mode-set command strobe |
| mode_addr | input | ADDR_W (12) | Mode word carried with the strobe |
| bank_busy | input | 1 | High while any bank is open or precharging |
| burst_start | input | 1 | Starts a burst |
| start_col | input | COL_W (8) | First column of the burst |
| start_is_write | input | 1 | Burst is a write |
| burst_stop | input | 1 | Terminates the active burst |
| col_addr | output | COL_W (8) | Current column |
| burst_valid | output | 1 | `col_addr` is a live beat |
| burst_last | output | 1 | Final beat of a fixed-length burst |
| cfg_burst_len | output | COL_W+1 (9) | Active burst length in beats |
| cfg_interleave | output | 1 | Active order is interleaved |
| cfg_cas_lat | output | 2 | Active CAS latency |
| mode_ready | output | 1 | A mode-set has taken effect since reset |
| mode_err | output | 1 | One-cycle pulse for a rejected mode-set |

## Verification
The assertions take for granted that the strobes are single-cycle pulses, sampled at clock edges, and that the mode word is stable while its strobe is high. They also assume a burst is never started and stopped in the same cycle unless a restart is intended. The stimulus changes every input only on the falling clock edge. It raises each strobe for exactly one cycle, and it issues a mode-set during a pending update only where rejection is the point of the test.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  // Active mode settings; lg is log2 of a fixed burst length.
  typedef struct packed {
    logic       full;
    logic [1:0] lg;
    logic       ilv;
    logic [1:0] cl;
    logic       wr_single;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_RESET = '{full: 1'b0, lg: 2'd0, ilv: 1'b0,
                                      cl: 2'd2, wr_single: 1'b0};

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_mode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DELAY  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_set,
  input  logic [ADDR_W-1:0] mode_addr,
  input  logic              bank_busy,
  output mode_cfg_t         cfg,
  output logic              ready,
  output logic              err
);
  localparam int CW = $clog2(DELAY + 1);

  mode_cfg_t      dec, pend_cfg;
  logic [CW-1:0]  pend_cnt;
  logic           len_ok, lat_ok, rsv_ok, busy, accept;

  always_comb begin
    dec    = CFG_RESET;
    len_ok = 1'b1;
    case (mode_addr[2:0])
      3'b000, 3'b001, 3'b010, 3'b011: begin
        dec.full = 1'b0;
        dec.lg   = mode_addr[1:0];
      end
      3'b111: begin
        dec.full = 1'b1;
        dec.lg   = 2'd0;
      end
      default: len_ok = 1'b0;
    endcase
    dec.ilv       = mode_addr[3] && (mode_addr[2:0] != 3'b111);
    lat_ok        = (mode_addr[6:4] == 3'd1) || (mode_addr[6:4] == 3'd2) ||
                    (mode_addr[6:4] == 3'd3);
    dec.cl        = mode_addr[5:4];
    dec.wr_single = mode_addr[9];
    rsv_ok        = (mode_addr[8:7] == 2'b00) && (mode_addr[ADDR_W-1:10] == '0);
    busy          = bank_busy || (pend_cnt != '0);
    accept        = mode_set && len_ok && lat_ok && rsv_ok && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= CFG_RESET;
      pend_cfg <= CFG_RESET;
      pend_cnt <= '0;
      ready    <= 1'b0;
      err      <= 1'b0;
    end else begin
      err <= mode_set && !accept;
      if (accept) begin
        pend_cfg <= dec;
        pend_cnt <= CW'(DELAY);
      end else if (pend_cnt != '0) begin
        pend_cnt <= pend_cnt - CW'(1);
        if (pend_cnt == CW'(1)) begin
          cfg   <= pend_cfg;
          ready <= 1'b1;
        end
      end
    end
  end

  assert_full_seq_R2: assert property (@(posedge clk) disable iff (rst)
    cfg.full |-> !cfg.ilv);
  assert_lat_legal_R3: assert property (@(posedge clk) disable iff (rst)
    cfg.cl != 2'd0);
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
    mode_set && !(len_ok && lat_ok && rsv_ok) |=> err);
  assert_pending_reject_R5: assert property (@(posedge clk) disable iff (rst)
    mode_set && (pend_cnt != '0) |=> err);
  assert_apply_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_cnt == CW'(1)) |=> (ready && cfg == $past(pend_cfg)));

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_mode_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_cfg_t        cfg,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_is_write,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);
  logic [COL_W-1:0] base_q, beat_q, mask_q, s_mask, beat_nx, col_nx;
  logic             ilv_q, full_q, s_full, s_ilv, one_beat;

  function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] n,
                                               input logic [COL_W-1:0] m,
                                               input logic             x);
    if (x) return b ^ (n & m);
    return (b & ~m) | ((b + n) & m);
  endfunction

  always_comb begin
    one_beat = start_is_write && cfg.wr_single;
    s_full   = cfg.full && !one_beat;
    s_ilv    = cfg.ilv && !one_beat;
    if (one_beat)      s_mask = '0;
    else if (cfg.full) s_mask = '1;
    else               s_mask = (COL_W'(1) << cfg.lg) - COL_W'(1);
    beat_nx = beat_q + COL_W'(1);
    col_nx  = col_at(base_q, beat_nx, mask_q, ilv_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      col    <= '0;
      valid  <= 1'b0;
      last   <= 1'b0;
    end else if (start) begin
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= s_mask;
      ilv_q  <= s_ilv;
      full_q <= s_full;
      col    <= start_col;
      valid  <= 1'b1;
      last   <= !s_full && (s_mask == '0);
    end else if (valid) begin
      if (stop || last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        beat_q <= beat_nx;
        col    <= col_nx;
        last   <= !full_q && (beat_nx == mask_q);
      end
    end
  end

  assert_in_block_R9: assert property (@(posedge clk) disable iff (rst)
    valid && !full_q |-> ((col ^ base_q) & ~mask_q) == '0);
  assert_full_no_last_R10: assert property (@(posedge clk) disable iff (rst)
    valid && full_q |-> !last);
  assert_last_ends_R11: assert property (@(posedge clk) disable iff (rst)
    last && !start |=> !valid);
  assert_last_valid_R11: assert property (@(posedge clk) disable iff (rst)
    last |-> valid);
  assert_stop_ends_R13: assert property (@(posedge clk) disable iff (rst)
    valid && stop && !start |=> !valid);

endmodule

// File: rtl/sdram_mode_burst_seq.sv
module sdram_mode_burst_seq
  import sdram_mode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8,
  parameter int DELAY  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_set,
  input  logic [ADDR_W-1:0] mode_addr,
  input  logic              bank_busy,
  input  logic              burst_start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_is_write,
  input  logic              burst_stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              burst_valid,
  output logic              burst_last,
  output logic [COL_W:0]    cfg_burst_len,
  output logic              cfg_interleave,
  output logic [1:0]        cfg_cas_lat,
  output logic              mode_ready,
  output logic              mode_err
);
  mode_cfg_t cfg;

  sdram_mode_reg #(.ADDR_W(ADDR_W), .DELAY(DELAY)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_set (mode_set),
    .mode_addr(mode_addr),
    .bank_busy(bank_busy),
    .cfg      (cfg),
    .ready    (mode_ready),
    .err      (mode_err)
  );

  sdram_burst_gen #(.COL_W(COL_W)) u_burst (
    .clk           (clk),
    .rst           (rst),
    .cfg           (cfg),
    .start         (burst_start),
    .start_col     (start_col),
    .start_is_write(start_is_write),
    .stop          (burst_stop),
    .col           (col_addr),
    .valid         (burst_valid),
    .last          (burst_last)
  );

  always_comb begin
    if (cfg.full) cfg_burst_len = (COL_W+1)'(1) << COL_W;
    else          cfg_burst_len = (COL_W+1)'(1) << cfg.lg;
    cfg_interleave = cfg.ilv;
    cfg_cas_lat    = cfg.cl;
  end

endmodule

// File: tb/tb_sdram_mode_burst_seq.sv
module tb_sdram_mode_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, mode_set, bank_busy, burst_start, start_is_write, burst_stop;
  logic [11:0] mode_addr;
  logic [7:0]  start_col, col_addr;
  logic        burst_valid, burst_last, cfg_interleave, mode_ready, mode_err;
  logic [8:0]  cfg_burst_len;
  logic [1:0]  cfg_cas_lat;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mode_burst_seq dut (
    .clk(clk), .rst(rst), .mode_set(mode_set), .mode_addr(mode_addr),
    .bank_busy(bank_busy), .burst_start(burst_start), .start_col(start_col),
    .start_is_write(start_is_write), .burst_stop(burst_stop),
    .col_addr(col_addr), .burst_valid(burst_valid), .burst_last(burst_last),
    .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .mode_ready(mode_ready), .mode_err(mode_err)
  );

  typedef struct packed {
    logic [11:0]     mode;
    logic [7:0]      col;
    logic            wr;
    logic [3:0]      n;
    logic [8:0]      len;
    logic            ilv;
    logic [1:0]      cl;
    logic [7:0][7:0] cols;   // beat i sits at index 7-i
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{12'h022, 8'h0D, 1'b0, 4'd4, 9'd4, 1'b0, 2'd2, {8'h0D,8'h0E,8'h0F,8'h0C,8'h00,8'h00,8'h00,8'h00}},
    '{12'h02A, 8'h0D, 1'b0, 4'd4, 9'd4, 1'b1, 2'd2, {8'h0D,8'h0C,8'h0F,8'h0E,8'h00,8'h00,8'h00,8'h00}},
    '{12'h033, 8'h15, 1'b0, 4'd8, 9'd8, 1'b0, 2'd3, {8'h15,8'h16,8'h17,8'h10,8'h11,8'h12,8'h13,8'h14}},
    '{12'h03B, 8'h15, 1'b0, 4'd8, 9'd8, 1'b1, 2'd3, {8'h15,8'h14,8'h17,8'h16,8'h11,8'h10,8'h13,8'h12}},
    '{12'h011, 8'h21, 1'b0, 4'd2, 9'd2, 1'b0, 2'd1, {8'h21,8'h20,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}},
    '{12'h020, 8'h40, 1'b1, 4'd1, 9'd1, 1'b0, 2'd2, {8'h40,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}},
    '{12'h233, 8'h33, 1'b1, 4'd1, 9'd8, 1'b0, 2'd3, {8'h33,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}},
    '{12'h233, 8'h33, 1'b0, 4'd8, 9'd8, 1'b0, 2'd3, {8'h33,8'h34,8'h35,8'h36,8'h37,8'h30,8'h31,8'h32}},
    '{12'h029, 8'h7F, 1'b0, 4'd2, 9'd2, 1'b1, 2'd2, {8'h7F,8'h7E,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [11:0] a);
    @(negedge clk); mode_set = 1'b1; mode_addr = a;
    @(negedge clk); mode_set = 1'b0;
  endtask

  task automatic go(input logic [7:0] c, input logic wr);
    @(negedge clk); burst_start = 1'b1; start_col = c; start_is_write = wr;
    @(negedge clk); burst_start = 1'b0;
  endtask

  task automatic chk_cfg(input string tag, input int len, input logic ilv, input int cl);
    chk({tag, " len"}, 32'(cfg_burst_len), 32'(len));
    chk({tag, " ilv"}, 32'(cfg_interleave), 32'(ilv));
    chk({tag, " cl"},  32'(cfg_cas_lat), 32'(cl));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; mode_set = 1'b0; mode_addr = '0; bank_busy = 1'b0;
    burst_start = 1'b0; start_col = '0; start_is_write = 1'b0; burst_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk_cfg("R7 reset", 1, 1'b0, 2);
    chk("R7 ready", 32'(mode_ready), 0);
    chk("R7 valid", 32'(burst_valid), 0);
    chk("R7 err", 32'(mode_err), 0);

    // R6 two-edge delay
    set_mode(12'h033);
    chk("R6 k", 32'(cfg_burst_len), 1);
    chk("R4 no err on valid", 32'(mode_err), 0);
    @(negedge clk);
    chk("R6 k+1", 32'(cfg_burst_len), 1);
    chk("R6 ready k+1", 32'(mode_ready), 0);
    @(negedge clk);
    chk_cfg("R6 k+2", 8, 1'b0, 3);
    chk("R6 ready", 32'(mode_ready), 1);

    // vector table: R1 R2 R3 R8 R9 R11 R12 R14
    for (int v = 0; v < NV; v++) begin
      set_mode(VECS[v].mode);
      chk("R4 accept", 32'(mode_err), 0);
      repeat (2) @(negedge clk);
      chk_cfg("R1/R2/R3 vec", int'(VECS[v].len), VECS[v].ilv, int'(VECS[v].cl));
      go(VECS[v].col, VECS[v].wr);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        chk("R8/R9/R12/R14 col", 32'(col_addr), 32'(VECS[v].cols[7-i]));
        chk("R14 valid", 32'(burst_valid), 1);
        chk("R11 last", 32'(burst_last), 32'(i == int'(VECS[v].n) - 1));
        @(negedge clk);
      end
      chk("R11 end", 32'(burst_valid), 0);
    end

    // R5 reject during pending update
    set_mode(12'h022);
    set_mode(12'h011);
    chk("R5 pending err", 32'(mode_err), 1);
    @(negedge clk);
    chk_cfg("R5 pending kept", 4, 1'b0, 2);
    repeat (3) @(negedge clk);
    chk_cfg("R5 pending later", 4, 1'b0, 2);

    // R5 reject while banks busy
    bank_busy = 1'b1;
    set_mode(12'h033);
    chk("R5 busy err", 32'(mode_err), 1);
    bank_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk_cfg("R5 busy kept", 4, 1'b0, 2);

    // R4 malformed words
    set_mode(12'h024);
    chk("R4 bad len", 32'(mode_err), 1);
    @(negedge clk);
    chk("R4 err pulse", 32'(mode_err), 0);
    set_mode(12'h002);
    chk("R4 bad cl", 32'(mode_err), 1);
    set_mode(12'h422);
    chk("R4 rsv10", 32'(mode_err), 1);
    set_mode(12'h0A2);
    chk("R4 rsv7", 32'(mode_err), 1);
    repeat (3) @(negedge clk);
    chk_cfg("R4 kept", 4, 1'b0, 2);

    // R10 full page with interleave bit forced sequential (R2)
    set_mode(12'h02F);
    repeat (2) @(negedge clk);
    chk_cfg("R2 full", 256, 1'b0, 2);
    go(8'hFE, 1'b0);
    for (int i = 0; i < 300; i++) begin
      chk("R10 col", 32'(col_addr), 32'(8'(8'hFE + i)));
      chk("R10 no last", 32'(burst_last), 0);
      chk("R10 valid", 32'(burst_valid), 1);
      @(negedge clk);
    end
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R13 stop full", 32'(burst_valid), 0);

    // R13 restart and stop on fixed burst
    set_mode(12'h033);
    repeat (2) @(negedge clk);
    go(8'h10, 1'b0);
    chk("R13 b0", 32'(col_addr), 32'h10);
    @(negedge clk);
    chk("R13 b1", 32'(col_addr), 32'h11);
    burst_start = 1'b1; start_col = 8'h44; burst_stop = 1'b1;
    @(negedge clk);
    burst_start = 1'b0; burst_stop = 1'b0;
    chk("R13 restart", 32'(col_addr), 32'h44);
    chk("R13 restart valid", 32'(burst_valid), 1);
    @(negedge clk);
    chk("R13 next", 32'(col_addr), 32'h45);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R13 stopped", 32'(burst_valid), 0);
    chk("R13 stopped last", 32'(burst_last), 0);

    finish_run();
  end
endmodule